// File: doc/BRIEF.md
# Controller Command Packet Responder

This block sits behind the byte-level handshake engine of a system management controller. Each completed host packet reaches it as a type byte, a command byte and one argument byte. The block answers with a reply packet, written one byte per cycle into the response buffer. Type 0 packets go to an attached peripheral bus, which is modelled here as a plain request/done port. Type 1 packets are controller commands, and each known command has a reply of fixed format. All other type codes are dropped. The other codes in use are 2 error, 3 timer, 4 power, 5 I2C and 6 power-manager.

The block also holds an autopoll enable flag. While the flag is set, it counts pulses on a poll tick input and issues a poll request to the peripheral bus every `POLL_DIV` ticks. With a 1 kHz tick and the default of 20, that gives 50 polls per second. Any data a poll returns is forwarded to the host as an unsolicited packet. A 32-bit seconds counter starts at 2082844800, which is Unix time zero expressed as seconds since 1 Jan 1904. It advances on a once-per-second tick and is returned by the time queries. The power-off and restart commands send their reply first and then raise a one-cycle shutdown or reset request.

A single state machine does the sequencing. The states are IDLE (accepts a packet or a pending poll), BUS_REQ (one-cycle bus request), BUS_WAIT (waits for bus done), DRAIN (holds a loaded reply while the host is still reading the previous one), SEND (streams the reply bytes) and SIDE (one-cycle side-effect pulse). The transitions are:
- IDLE→DRAIN on a known controller command.
- IDLE→BUS_REQ on a type 0 packet or a due poll.
- BUS_REQ→BUS_WAIT.
- BUS_WAIT→DRAIN when bus done arrives with a reply to send.
- BUS_WAIT→IDLE when a poll returns nothing.
- DRAIN→SEND once the host buffer is free.
- SEND→SIDE after the last byte of a power-off or restart reply.
- SEND→IDLE after the last byte of any other reply.
- SIDE→IDLE.

Top module: `ctl_pkt_responder`

## Requirements
- R1: After reset the block is in IDLE with `pkt_ready` high, no reply, request or pulse output active, autopoll off, and the seconds counter at `SEC_INIT` (default 2082844800).
- R2: Command 0x01 sets autopoll when its argument is nonzero and clears it otherwise. The reply is {0x01, argument}.
- R3: Commands 0x03 and 0x09 reply with seven bytes {0x01, 0x00, 0x00, s[31:24], s[23:16], s[15:8], s[7:0]}, where s is the seconds counter.
- R4: The seconds counter increases by one on every cycle in which `sec_tick` is high.
- R5: Commands 0x13, 0x14, 0x19 and 0x21 reply {0x01, 0x00}.
- R6: Command 0x0A replies {0x01, 0x00}, and `shutdown_req` is then high for exactly the one cycle after the last reply byte. Command 0x11 does the same with `reset_req`.
- R7: A type 0 packet produces one `bus_req` cycle with `bus_poll` low and `bus_cmd` equal to the command byte. If `bus_status` is 0, the reply is {0x00, 0x00, data bytes 0..n-1}, where n is `bus_count` clamped to `MAXD` and data byte k is `bus_data[8k+7:8k]`. If `bus_status` is a nonzero code e, the reply is {0x00, e}.
- R8: While autopoll is on, every `POLL_DIV` poll ticks cause one `bus_req` with `bus_poll` high and `bus_cmd` 0. If the poll succeeds with n > 0, the reply is {0x00, 0x40, data bytes}. An error status or a count of zero produces no reply. Fewer ticks cause no poll, and no poll is made while autopoll is off.
- R9: Command codes other than those in R2, R3, R5 and R6, and packet types other than 0 and 1, produce no reply, no request and no pulse, and leave the autopoll flag unchanged.
- R10: No reply byte is sent while `host_busy` is high. The loaded reply waits and is sent in full once it falls.
- R11: If a host packet and a poll become due in the same cycle, the host packet is served first. The poll is kept pending and runs afterwards.
- R12: Reply bytes are sent on consecutive cycles with `rsp_valid` high, and `rsp_last` is high on the final byte only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | Completed host packet present |
| pkt_type | input | 8 | Packet byte 0, the type code |
| pkt_cmd | input | 8 | Packet byte 1, the command code |
| pkt_arg | input | 8 | Packet byte 2, the argument |
| pkt_ready | output | 1 | Block is in IDLE and takes a packet |
| host_busy | input | 1 | Host is still reading the previous reply |
| rsp_valid | output | 1 | Reply byte valid |
| rsp_data | output | 8 | Reply byte |
| rsp_last | output | 1 | Final byte of the reply |
| poll_tick | input | 1 | Poll time base pulse |
| sec_tick | input | 1 | One-second pulse |
| bus_req | output | 1 | Peripheral bus request pulse |
| bus_poll | output | 1 | The request is an autopoll |
| bus_cmd | output | 8 | Command for the peripheral bus |
| bus_done | input | 1 | Peripheral bus response present |
| bus_status | input | 8 | 0 for success, else an error code |
| bus_count | input | CW | Number of returned data bytes |
| bus_data | input | 8*MAXD | Returned data bytes, byte k at bits 8k+7:8k |
| shutdown_req | output | 1 | One-cycle power-off request |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The main overlap is an incoming host packet and a poll falling due in the same clock. The bench sets this up by priming the poll divider to one tick short of its limit. It then drives the final `poll_tick` in the same cycle as a `pkt_valid` carrying command 0x14. The run passes if the controller reply {0x01, 0x00} comes out first, the poll request count then rises by one, and the poll reply follows with the expected data. A second overlap is a reply becoming ready while the host is still busy. This is provoked by holding `host_busy` high across a command, and is judged by no byte appearing until the signal is released.

// File: rtl/cpr_pkg.sv
package cpr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BUS_REQ,
        ST_BUS_WAIT,
        ST_DRAIN,
        ST_SEND,
        ST_SIDE
    } cpr_state_e;

    typedef enum logic [1:0] {
        SIDE_NONE,
        SIDE_SHUT,
        SIDE_RST
    } cpr_side_e;

    typedef enum logic [1:0] {
        SRC_CTL,
        SRC_BUS,
        SRC_POLL
    } cpr_src_e;

    localparam logic [7:0] PT_BUS       = 8'h00;
    localparam logic [7:0] PT_CTL       = 8'h01;
    localparam logic [7:0] CMD_AUTOPOLL = 8'h01;
    localparam logic [7:0] CMD_TIME_GET = 8'h03;
    localparam logic [7:0] CMD_TIME_SET = 8'h09;
    localparam logic [7:0] CMD_POWEROFF = 8'h0A;
    localparam logic [7:0] CMD_RESTART  = 8'h11;
    localparam logic [7:0] CMD_SRVFLAG  = 8'h13;
    localparam logic [7:0] CMD_RATE     = 8'h14;
    localparam logic [7:0] CMD_DEVLIST  = 8'h19;
    localparam logic [7:0] CMD_PWRMSG   = 8'h21;
    localparam logic [7:0] POLL_TAG     = 8'h40;

endpackage

// File: rtl/cpr_poll_timer.sv
module cpr_poll_timer #(
    parameter int POLL_DIV = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic take,
    output logic pend
);
    localparam int CNTW = (POLL_DIV > 2) ? $clog2(POLL_DIV) : 1;
    localparam logic [CNTW-1:0] CNT_MAX = CNTW'(POLL_DIV - 1);

    logic [CNTW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else if (!en) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else begin
            if (tick) begin
                cnt <= (cnt == CNT_MAX) ? '0 : cnt + CNTW'(1);
            end
            if (take) begin
                pend <= 1'b0;
            end
            if (tick && (cnt == CNT_MAX)) begin
                pend <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cpr_seconds.sv
module cpr_seconds #(
    parameter logic [31:0] SEC_INIT = 32'd2082844800
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    output logic [31:0] secs
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            secs <= SEC_INIT;
        end else if (tick) begin
            secs <= secs + 32'd1;
        end
    end
endmodule

// File: rtl/cpr_reply_build.sv
module cpr_reply_build
    import cpr_pkg::*;
#(
    parameter int MAXD = 4,
    parameter int CW   = 3,
    parameter int RBUF = 7,
    parameter int LW   = 3
) (
    input  cpr_src_e              src,
    input  logic [7:0]            cmd,
    input  logic [7:0]            arg,
    input  logic [31:0]           secs,
    input  logic [7:0]            bus_status,
    input  logic [CW-1:0]         bus_count,
    input  logic [MAXD*8-1:0]     bus_data,
    output logic [RBUF-1:0][7:0]  rep_bytes,
    output logic [LW-1:0]         rep_len,
    output logic                  rep_ok,
    output cpr_side_e             rep_side
);
    logic [CW-1:0] eff;

    always_comb begin
        eff = (bus_count > CW'(MAXD)) ? CW'(MAXD) : bus_count;
    end

    always_comb begin
        rep_bytes = '0;
        rep_len   = '0;
        rep_ok    = 1'b0;
        rep_side  = SIDE_NONE;
        unique case (src)
            SRC_CTL: begin
                rep_bytes[0] = PT_CTL;
                case (cmd)
                    CMD_AUTOPOLL: begin
                        rep_ok       = 1'b1;
                        rep_len      = LW'(2);
                        rep_bytes[1] = arg;
                    end
                    CMD_TIME_GET, CMD_TIME_SET: begin
                        rep_ok       = 1'b1;
                        rep_len      = LW'(7);
                        rep_bytes[3] = secs[31:24];
                        rep_bytes[4] = secs[23:16];
                        rep_bytes[5] = secs[15:8];
                        rep_bytes[6] = secs[7:0];
                    end
                    CMD_SRVFLAG, CMD_RATE, CMD_DEVLIST, CMD_PWRMSG: begin
                        rep_ok  = 1'b1;
                        rep_len = LW'(2);
                    end
                    CMD_POWEROFF: begin
                        rep_ok   = 1'b1;
                        rep_len  = LW'(2);
                        rep_side = SIDE_SHUT;
                    end
                    CMD_RESTART: begin
                        rep_ok   = 1'b1;
                        rep_len  = LW'(2);
                        rep_side = SIDE_RST;
                    end
                    default: rep_ok = 1'b0;
                endcase
            end
            SRC_BUS, SRC_POLL: begin
                rep_bytes[0] = PT_BUS;
                if (bus_status != 8'h00) begin
                    rep_bytes[1] = bus_status;
                    rep_len      = LW'(2);
                    rep_ok       = (src == SRC_BUS);
                end else begin
                    rep_bytes[1] = (src == SRC_POLL) ? POLL_TAG : 8'h00;
                    for (int k = 0; k < MAXD; k++) begin
                        if (CW'(k) < eff) begin
                            rep_bytes[2+k] = bus_data[8*k +: 8];
                        end
                    end
                    rep_len = LW'(2) + LW'(eff);
                    rep_ok  = (src == SRC_BUS) || (eff != '0);
                end
            end
            default: rep_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/ctl_pkt_responder.sv
module ctl_pkt_responder
    import cpr_pkg::*;
#(
    parameter int          MAXD     = 4,
    parameter int          POLL_DIV = 20,
    parameter logic [31:0] SEC_INIT = 32'd2082844800,
    localparam int         CW       = $clog2(MAXD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    input  logic [7:0]        pkt_type,
    input  logic [7:0]        pkt_cmd,
    input  logic [7:0]        pkt_arg,
    output logic              pkt_ready,
    input  logic              host_busy,
    output logic              rsp_valid,
    output logic [7:0]        rsp_data,
    output logic              rsp_last,
    input  logic              poll_tick,
    input  logic              sec_tick,
    output logic              bus_req,
    output logic              bus_poll,
    output logic [7:0]        bus_cmd,
    input  logic              bus_done,
    input  logic [7:0]        bus_status,
    input  logic [CW-1:0]     bus_count,
    input  logic [MAXD*8-1:0] bus_data,
    output logic              shutdown_req,
    output logic              reset_req
);
    localparam int RBUF = (MAXD + 2 > 7) ? MAXD + 2 : 7;
    localparam int LW   = $clog2(RBUF + 1);
    localparam int IW   = $clog2(RBUF);

    cpr_state_e            state;
    cpr_src_e              src_q;
    cpr_src_e              build_src;
    cpr_side_e             side_q;
    logic [7:0]            cmd_q;
    logic [RBUF-1:0][7:0]  rbuf;
    logic [LW-1:0]         rlen;
    logic [IW-1:0]         idx;
    logic                  autopoll_q;
    logic [31:0]           secs;
    logic                  poll_pend;
    logic                  poll_take;
    logic                  at_last;

    logic [RBUF-1:0][7:0]  rep_bytes;
    logic [LW-1:0]         rep_len;
    logic                  rep_ok;
    cpr_side_e             rep_side;

    cpr_seconds #(.SEC_INIT(SEC_INIT)) u_seconds (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (sec_tick),
        .secs  (secs)
    );

    cpr_poll_timer #(.POLL_DIV(POLL_DIV)) u_poll_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (autopoll_q),
        .tick  (poll_tick),
        .take  (poll_take),
        .pend  (poll_pend)
    );

    assign build_src = (state == ST_IDLE) ? SRC_CTL : src_q;

    cpr_reply_build #(
        .MAXD (MAXD),
        .CW   (CW),
        .RBUF (RBUF),
        .LW   (LW)
    ) u_reply_build (
        .src        (build_src),
        .cmd        (pkt_cmd),
        .arg        (pkt_arg),
        .secs       (secs),
        .bus_status (bus_status),
        .bus_count  (bus_count),
        .bus_data   (bus_data),
        .rep_bytes  (rep_bytes),
        .rep_len    (rep_len),
        .rep_ok     (rep_ok),
        .rep_side   (rep_side)
    );

    // A host packet in IDLE wins over a pending poll.
    assign poll_take = (state == ST_IDLE) && !pkt_valid && poll_pend && autopoll_q;
    assign at_last   = (LW'(idx) == rlen - LW'(1));

    // State register and datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            src_q      <= SRC_CTL;
            side_q     <= SIDE_NONE;
            cmd_q      <= '0;
            rbuf       <= '0;
            rlen       <= '0;
            idx        <= '0;
            autopoll_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (pkt_valid) begin
                        if (pkt_type == PT_BUS) begin
                            src_q <= SRC_BUS;
                            cmd_q <= pkt_cmd;
                            state <= ST_BUS_REQ;
                        end else if ((pkt_type == PT_CTL) && rep_ok) begin
                            rbuf   <= rep_bytes;
                            rlen   <= rep_len;
                            side_q <= rep_side;
                            if (pkt_cmd == CMD_AUTOPOLL) begin
                                autopoll_q <= (pkt_arg != 8'h00);
                            end
                            state <= ST_DRAIN;
                        end
                    end else if (poll_take) begin
                        src_q <= SRC_POLL;
                        cmd_q <= 8'h00;
                        state <= ST_BUS_REQ;
                    end
                end
                ST_BUS_REQ: begin
                    state <= ST_BUS_WAIT;
                end
                ST_BUS_WAIT: begin
                    if (bus_done) begin
                        if (rep_ok) begin
                            rbuf   <= rep_bytes;
                            rlen   <= rep_len;
                            side_q <= SIDE_NONE;
                            state  <= ST_DRAIN;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (!host_busy) begin
                        idx   <= '0;
                        state <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (at_last) begin
                        state <= (side_q != SIDE_NONE) ? ST_SIDE : ST_IDLE;
                    end else begin
                        idx <= idx + IW'(1);
                    end
                end
                ST_SIDE: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from state.
    always_comb begin
        pkt_ready    = (state == ST_IDLE);
        rsp_valid    = (state == ST_SEND);
        rsp_data     = (state == ST_SEND) ? rbuf[idx] : 8'h00;
        rsp_last     = (state == ST_SEND) && at_last;
        bus_req      = (state == ST_BUS_REQ);
        bus_poll     = (state == ST_BUS_REQ) && (src_q == SRC_POLL);
        bus_cmd      = (state == ST_BUS_REQ) ? cmd_q : 8'h00;
        shutdown_req = (state == ST_SIDE) && (side_q == SIDE_SHUT);
        reset_req    = (state == ST_SIDE) && (side_q == SIDE_RST);
    end
endmodule

// File: rtl/cpr_checker.sv
module cpr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        pkt_valid,
    input logic [7:0]  pkt_type,
    input logic [7:0]  pkt_cmd,
    input logic [7:0]  pkt_arg,
    input logic        pkt_ready,
    input logic        host_busy,
    input logic        rsp_valid,
    input logic        rsp_last,
    input logic        sec_tick,
    input logic        bus_req,
    input logic        bus_poll,
    input logic        shutdown_req,
    input logic        reset_req,
    input logic        autopoll,
    input logic [31:0] secs
);
    assert_idle_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (pkt_ready && !rsp_valid && !bus_req));

    assert_autopoll_follows_arg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ready && pkt_type == 8'h01 && pkt_cmd == 8'h01)
        |=> (autopoll == ($past(pkt_arg) != 8'h00)));

    assert_secs_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> (secs == $past(secs) + 32'd1));

    assert_shut_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutdown_req) |-> $past(rsp_last));

    assert_reset_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req) |-> $past(rsp_last));

    assert_side_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(shutdown_req && reset_req));

    assert_req_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> !bus_req);

    assert_poll_needs_autopoll_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_poll |-> autopoll);

    assert_foreign_type_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ready && pkt_type > 8'h01) |=> (pkt_ready && $stable(autopoll)));

    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_busy && !rsp_valid) |=> !rsp_valid);

    assert_packet_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ready) |=> !bus_poll);

    assert_burst_contiguous_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_last) |=> rsp_valid);
endmodule

bind ctl_pkt_responder cpr_checker u_cpr_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .pkt_valid    (pkt_valid),
    .pkt_type     (pkt_type),
    .pkt_cmd      (pkt_cmd),
    .pkt_arg      (pkt_arg),
    .pkt_ready    (pkt_ready),
    .host_busy    (host_busy),
    .rsp_valid    (rsp_valid),
    .rsp_last     (rsp_last),
    .sec_tick     (sec_tick),
    .bus_req      (bus_req),
    .bus_poll     (bus_poll),
    .shutdown_req (shutdown_req),
    .reset_req    (reset_req),
    .autopoll     (autopoll_q),
    .secs         (secs)
);

// File: tb/ctl_pkt_responder_bench.sv
module ctl_pkt_responder_bench;
    localparam int MAXD     = 3;
    localparam int POLL_DIV = 4;
    localparam int CW       = $clog2(MAXD + 1);
    localparam logic [31:0] SEC0 = 32'd2082844800;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pkt_valid = 1'b0;
    logic [7:0] pkt_type = '0, pkt_cmd = '0, pkt_arg = '0;
    logic pkt_ready;
    logic host_busy = 1'b0;
    logic rsp_valid, rsp_last;
    logic [7:0] rsp_data;
    logic poll_tick = 1'b0, sec_tick = 1'b0;
    logic bus_req, bus_poll;
    logic [7:0] bus_cmd;
    logic bus_done = 1'b0;
    logic [7:0] bus_status = '0;
    logic [CW-1:0] bus_count = '0;
    logic [MAXD*8-1:0] bus_data = '0;
    logic shutdown_req, reset_req;

    always #5 clk = ~clk;

    ctl_pkt_responder #(.MAXD(MAXD), .POLL_DIV(POLL_DIV), .SEC_INIT(SEC0)) u_ctl_pkt_responder (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_type(pkt_type),
        .pkt_cmd(pkt_cmd), .pkt_arg(pkt_arg), .pkt_ready(pkt_ready), .host_busy(host_busy),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
        .poll_tick(poll_tick), .sec_tick(sec_tick), .bus_req(bus_req), .bus_poll(bus_poll),
        .bus_cmd(bus_cmd), .bus_done(bus_done), .bus_status(bus_status),
        .bus_count(bus_count), .bus_data(bus_data),
        .shutdown_req(shutdown_req), .reset_req(reset_req)
    );

    int checks = 0;
    int fails  = 0;

    // Peripheral bus model
    logic [7:0] m_status = '0;
    int         m_count  = 0;
    int         req_cnt  = 0;
    int         poll_cnt = 0;
    logic [7:0] last_cmd = '0;
    logic       last_poll = 1'b0;
    int         dly = 0;

    function automatic logic [7:0] pay(input logic [7:0] c, input int k);
        return c + 8'(k * 17) + 8'h31;
    endfunction

    always @(negedge clk) begin
        bus_done = 1'b0;
        if (dly == 1) begin
            bus_done   = 1'b1;
            bus_status = m_status;
            bus_count  = CW'(m_count);
            for (int k = 0; k < MAXD; k++) bus_data[8*k +: 8] = pay(last_cmd, k);
        end
        if (dly > 0) dly--;
        if (bus_req) begin
            req_cnt++;
            if (bus_poll) poll_cnt++;
            last_cmd  = bus_cmd;
            last_poll = bus_poll;
            dly = 3;
        end
    end

    // Reply capture
    logic [7:0] got [16];
    logic [7:0] exp_b [16];
    int gotn;
    logic gap, gotshut, gotrst;

    task automatic send_pkt(input logic [7:0] t, input logic [7:0] c, input logic [7:0] a,
                            input logic with_tick);
        @(negedge clk);
        while (!pkt_ready) @(negedge clk);
        pkt_valid = 1'b1; pkt_type = t; pkt_cmd = c; pkt_arg = a;
        poll_tick = with_tick;
        @(negedge clk);
        pkt_valid = 1'b0; poll_tick = 1'b0;
    endtask

    task automatic collect(input int maxw);
        int w;
        w = 0; gotn = 0; gap = 1'b0; gotshut = 1'b0; gotrst = 1'b0;
        @(negedge clk);
        while (!rsp_valid && w < maxw) begin
            @(negedge clk);
            w++;
        end
        if (!rsp_valid) return;
        while (1) begin
            got[gotn] = rsp_data;
            gotn++;
            if (rsp_last || gotn >= 16) break;
            @(negedge clk);
            if (!rsp_valid) begin
                gap = 1'b1;
                break;
            end
        end
        @(negedge clk);
        gotshut = shutdown_req;
        gotrst  = reset_req;
    endtask

    task automatic check_reply(input string req, input int xn, input logic xs, input logic xr);
        logic ok;
        ok = (gotn == xn) && !gap && (gotshut == xs) && (gotrst == xr);
        for (int i = 0; i < xn && i < gotn; i++) if (got[i] !== exp_b[i]) ok = 1'b0;
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual n=%0d [%h %h %h %h %h %h %h] gap=%0d shut=%0d rst=%0d, expected n=%0d [%h %h %h %h %h %h %h] shut=%0d rst=%0d",
                     req, gotn, got[0], got[1], got[2], got[3], got[4], got[5], got[6], gap, gotshut, gotrst,
                     xn, exp_b[0], exp_b[1], exp_b[2], exp_b[3], exp_b[4], exp_b[5], exp_b[6], xs, xr);
        end
    endtask

    task automatic check_val(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic tick_poll(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); poll_tick = 1'b1;
            @(negedge clk); poll_tick = 1'b0;
        end
    endtask

    task automatic clear_exp();
        for (int i = 0; i < 16; i++) begin
            exp_b[i] = 8'h00;
            got[i]   = 8'h00;
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung run expected completion");
        finish_run();
    end

    logic [31:0] sec_model;

    initial begin
        int n;
        logic xs, xr;
        int pc;
        sec_model = SEC0;
        repeat (4) @(negedge clk);
        // R1: reset state
        check_val("R1 pkt_ready", int'(pkt_ready), 1);
        check_val("R1 outputs idle", int'(rsp_valid | bus_req | shutdown_req | reset_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_val("R1 ready after release", int'(pkt_ready), 1);

        // Sweep of all controller command codes (R2 R3 R5 R6 R9, R12 via contiguity)
        for (int c = 0; c < 256; c++) begin
            logic [7:0] a;
            a = 8'(c) ^ 8'h5A;
            clear_exp();
            n = 0; xs = 1'b0; xr = 1'b0;
            exp_b[0] = 8'h01;
            case (8'(c))
                8'h01: begin n = 2; exp_b[1] = a; end
                8'h03, 8'h09: begin
                    n = 7;
                    exp_b[3] = sec_model[31:24]; exp_b[4] = sec_model[23:16];
                    exp_b[5] = sec_model[15:8];  exp_b[6] = sec_model[7:0];
                end
                8'h13, 8'h14, 8'h19, 8'h21: n = 2;
                8'h0A: begin n = 2; xs = 1'b1; end
                8'h11: begin n = 2; xr = 1'b1; end
                default: n = 0;
            endcase
            send_pkt(8'h01, 8'(c), a, 1'b0);
            collect(12);
            if (c == 1)                  check_reply("R2 autopoll on reply", n, xs, xr);
            else if (c == 3 || c == 9)   check_reply("R3 R1 time reply at reset value", n, xs, xr);
            else if (n == 0)             check_reply("R9 unknown command silent", n, xs, xr);
            else if (xs || xr)           check_reply("R6 power command reply and pulse", n, xs, xr);
            else                         check_reply("R5 R12 acknowledge reply", n, xs, xr);
        end
        check_val("R9 no bus request from controller sweep", req_cnt, 0);

        // R2: clear autopoll, then no polls
        clear_exp(); exp_b[0] = 8'h01; exp_b[1] = 8'h00;
        send_pkt(8'h01, 8'h01, 8'h00, 1'b0);
        collect(12);
        check_reply("R2 autopoll off reply", 2, 1'b0, 1'b0);
        tick_poll(2 * POLL_DIV);
        repeat (10) @(negedge clk);
        check_val("R2 R8 no poll while off", poll_cnt, 0);

        // R4: seconds ticks
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); sec_tick = 1'b1;
            @(negedge clk); sec_tick = 1'b0;
        end
        sec_model = sec_model + 32'd5;
        clear_exp(); exp_b[0] = 8'h01;
        exp_b[3] = sec_model[31:24]; exp_b[4] = sec_model[23:16];
        exp_b[5] = sec_model[15:8];  exp_b[6] = sec_model[7:0];
        send_pkt(8'h01, 8'h03, 8'h00, 1'b0);
        collect(12);
        check_reply("R4 R3 time after five ticks", 7, 1'b0, 1'b0);

        // R9: foreign packet types are dropped
        for (int t = 2; t < 8; t++) begin
            clear_exp();
            send_pkt(8'(t), 8'h0A, 8'h01, 1'b0);
            collect(12);
            check_reply("R9 foreign type silent", 0, 1'b0, 1'b0);
        end
        check_val("R9 no bus request from foreign types", req_cnt, 0);

        // R7: peripheral bus requests
        for (int cnt = 0; cnt <= MAXD; cnt++) begin
            logic [7:0] bc;
            bc = 8'h20 + 8'(cnt);
            m_status = 8'h00; m_count = cnt;
            clear_exp();
            for (int k = 0; k < cnt; k++) exp_b[2+k] = pay(bc, k);
            send_pkt(8'h00, bc, 8'h00, 1'b0);
            collect(30);
            check_reply("R7 bus success reply", 2 + cnt, 1'b0, 1'b0);
            check_val("R7 bus_cmd forwarded", int'(last_cmd), int'(bc));
            check_val("R7 bus_poll low for host", int'(last_poll), 0);
        end
        for (int e = 0; e < 4; e++) begin
            logic [7:0] ev;
            ev = (e == 0) ? 8'h01 : (e == 1) ? 8'h7F : (e == 2) ? 8'h80 : 8'hFF;
            m_status = ev; m_count = 2;
            clear_exp(); exp_b[1] = ev;
            send_pkt(8'h00, 8'h44, 8'h00, 1'b0);
            collect(30);
            check_reply("R7 bus error reply", 2, 1'b0, 1'b0);
        end

        // R8: autopoll behaviour
        clear_exp(); exp_b[0] = 8'h01; exp_b[1] = 8'h07;
        send_pkt(8'h01, 8'h01, 8'h07, 1'b0);
        collect(12);
        check_reply("R2 autopoll enable reply", 2, 1'b0, 1'b0);
        // R9: unknown command and foreign type keep autopoll on
        send_pkt(8'h01, 8'h55, 8'h00, 1'b0);
        collect(12);
        check_reply("R9 unknown command silent with autopoll", 0, 1'b0, 1'b0);
        send_pkt(8'h03, 8'h01, 8'h00, 1'b0);
        collect(12);
        check_reply("R9 timer type silent with autopoll", 0, 1'b0, 1'b0);
        pc = poll_cnt;
        tick_poll(POLL_DIV - 1);
        repeat (10) @(negedge clk);
        check_val("R8 no poll one tick short", poll_cnt, pc);
        m_status = 8'h00; m_count = 2;
        clear_exp(); exp_b[1] = 8'h40; exp_b[2] = pay(8'h00, 0); exp_b[3] = pay(8'h00, 1);
        tick_poll(1);
        collect(30);
        check_reply("R8 R9 poll reply after full period", 4, 1'b0, 1'b0);
        check_val("R8 poll request count", poll_cnt, pc + 1);
        check_val("R8 poll cmd zero", int'(last_cmd), 0);
        m_status = 8'h05;
        tick_poll(POLL_DIV);
        collect(30);
        check_reply("R8 poll error silent", 0, 1'b0, 1'b0);
        check_val("R8 poll error still requested", poll_cnt, pc + 2);
        m_status = 8'h00; m_count = 0;
        tick_poll(POLL_DIV);
        collect(30);
        check_reply("R8 empty poll silent", 0, 1'b0, 1'b0);
        check_val("R8 empty poll requested", poll_cnt, pc + 3);

        // R11: host packet and poll due in the same cycle
        m_count = 1;
        tick_poll(POLL_DIV - 1);
        repeat (3) @(negedge clk);
        pc = poll_cnt;
        clear_exp(); exp_b[0] = 8'h01;
        send_pkt(8'h01, 8'h14, 8'h00, 1'b1);
        collect(12);
        check_reply("R11 host reply first", 2, 1'b0, 1'b0);
        check_val("R11 poll not yet issued", poll_cnt, pc);
        clear_exp(); exp_b[1] = 8'h40; exp_b[2] = pay(8'h00, 0);
        collect(40);
        check_reply("R11 pending poll served after", 3, 1'b0, 1'b0);
        check_val("R11 poll count", poll_cnt, pc + 1);

        // disable autopoll again
        clear_exp(); exp_b[0] = 8'h01;
        send_pkt(8'h01, 8'h01, 8'h00, 1'b0);
        collect(12);
        check_reply("R2 autopoll disable reply", 2, 1'b0, 1'b0);

        // R10: host busy holds the reply
        host_busy = 1'b1;
        clear_exp(); exp_b[0] = 8'h01;
        send_pkt(8'h01, 8'h19, 8'h00, 1'b0);
        collect(15);
        check_reply("R10 no byte while busy", 0, 1'b0, 1'b0);
        @(negedge clk); host_busy = 1'b0;
        collect(10);
        check_reply("R10 R12 reply after busy drops", 2, 1'b0, 1'b0);

        // R6 again under busy hold: pulse still follows last byte
        host_busy = 1'b1;
        send_pkt(8'h01, 8'h11, 8'h00, 1'b0);
        repeat (6) @(negedge clk);
        host_busy = 1'b0;
        collect(10);
        check_reply("R6 restart pulse after delayed reply", 2, 1'b0, 1'b1);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule